// File: doc/BRIEF.md
# Codec Clock Start-Up Sequencer

This block brings an audio codec from reset into PLL master operation without software. When `start_i` is pulsed, it holds the codec power-down output low for at least 150 ns and then releases it. It then sends a fixed five-entry register script through a write-request handshake made of address, data, valid and ready. The serial control bus that carries these writes sits outside the block.

The script first programs the clock-related registers: the interface format, the PLL reference, the sample rate, the bit-clock ratio and master/slave mode. It then turns on the common-mode reference. The last write enables the PLL, master mode and the master-clock output together. After that write is accepted, the block waits the PLL lock time (40 ms by default), measured in system-clock cycles, and then raises `done_o`. At that point the codec's frame, bit and master clocks are valid. Both intervals come from the system clock frequency parameter and are rounded up to whole cycles.

Top module: `codec_clk_seq`

## Requirements
- R1: While `rst_ni` is low, and after reset before any start, `pdn_o`, `busy_o`, `done_o` and `wr_valid_o` are all 0.
- R2: After an accepted start, `pdn_o` stays low for exactly ceil(RST_LOW_NS * CLK_HZ / 1e9) cycles (at least 1) while `busy_o` is high, then goes high and stays high until the next accepted start.
- R3: The writes leave in this order as {address, data}: {02h,22h}, {03h,02h}, {01h,F4h}, {00h,01h}, {02h,27h}. The reference enable (00h bit 0) therefore comes before the PLL enable (02h bit 0). No write is offered while `pdn_o` is low.
- R4: A write offered with `wr_ready_i` low stays offered, with unchanged address and data, until it is accepted. Exactly one entry is consumed per cycle in which both valid and ready are high.
- R5: `done_o` rises exactly LOCK_CYC = ceil(LOCK_US * CLK_HZ / 1e6) cycles after the clock edge that accepts the PLL-enable write. No write is offered during that wait.
- R6: `busy_o` is high from the cycle after an accepted start until `done_o` rises. `busy_o` and `done_o` are never high together. `done_o` stays high until the next start.
- R7: A start received while `busy_o` is high is ignored: the script, the power-down pin and the lock timing continue unchanged.
- R8: A start received while `done_o` is high reruns the whole sequence, including a fresh low phase on `pdn_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin the start-up sequence |
| pdn_o | output | 1 | Codec power-down pin, low = held in reset |
| wr_addr_o | output | AW | Register address of the offered write |
| wr_data_o | output | DW | Register data of the offered write |
| wr_valid_o | output | 1 | Write offered |
| wr_ready_i | input | 1 | Write accepted this cycle when high with valid |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Lock wait expired, codec clocks valid |

## Verification
The assertions check, on every cycle, the properties that hold locally. A stalled write keeps its address and data. No write appears while the power-down pin is low. Busy and done are mutually exclusive. The power-down pin never falls in the middle of a sequence. The timer counts down by one each cycle. The exact lengths of the reset pulse and the lock wait, the order of the script's contents, the rounding at a non-integer clock ratio, and the restart from done can only be shown by the bench scenarios. These scenarios compare a scoreboard of expected writes and measured cycle counts against values derived from the parameters.

// File: rtl/codec_seq_pkg.sv
package codec_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RST,
    S_WR,
    S_LOCK,
    S_DONE
  } seq_state_e;

  localparam int unsigned SCRIPT_LEN = 5;

  function automatic longint unsigned ceil_div(longint unsigned num, longint unsigned den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  output logic          expired_o
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  // R2 / R5: interval length relies on a strict one-per-cycle countdown
  p_count_down_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/seq_script_rom.sv
module seq_script_rom #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8,
  parameter int unsigned IW = 3
) (
  input  logic [IW-1:0] idx_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);

  // clock setup, then reference on, then PLL + master + mclk out
  always_comb begin
    unique case (idx_i)
      IW'(0):  begin addr_o = AW'(8'h02); data_o = DW'(8'h22); end
      IW'(1):  begin addr_o = AW'(8'h03); data_o = DW'(8'h02); end
      IW'(2):  begin addr_o = AW'(8'h01); data_o = DW'(8'hF4); end
      IW'(3):  begin addr_o = AW'(8'h00); data_o = DW'(8'h01); end
      IW'(4):  begin addr_o = AW'(8'h02); data_o = DW'(8'h27); end
      default: begin addr_o = '0;         data_o = '0;         end
    endcase
  end

endmodule

// File: rtl/codec_clk_seq.sv
module codec_clk_seq
  import codec_seq_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 100_000_000,
  parameter int unsigned RST_LOW_NS = 150,
  parameter int unsigned LOCK_US    = 40_000,
  parameter int unsigned AW         = 8,
  parameter int unsigned DW         = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          pdn_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          wr_valid_o,
  input  logic          wr_ready_i,
  output logic          busy_o,
  output logic          done_o
);

  localparam longint unsigned RST_RAW =
    ceil_div(longint'(RST_LOW_NS) * longint'(CLK_HZ), 64'd1_000_000_000);
  localparam longint unsigned LOCK_RAW =
    ceil_div(longint'(LOCK_US) * longint'(CLK_HZ), 64'd1_000_000);
  localparam int unsigned RST_CYC  = (RST_RAW  < 1) ? 1 : int'(RST_RAW);
  localparam int unsigned LOCK_CYC = (LOCK_RAW < 1) ? 1 : int'(LOCK_RAW);
  localparam int unsigned MAX_CYC  = (RST_CYC > LOCK_CYC) ? RST_CYC : LOCK_CYC;
  localparam int unsigned TW       = $clog2(MAX_CYC + 1);
  localparam int unsigned IW       = $clog2(SCRIPT_LEN);
  localparam logic [IW-1:0] LAST_IDX = IW'(SCRIPT_LEN - 1);

  seq_state_e    state_q;
  logic [IW-1:0] idx_q;
  logic          pdn_q;
  logic          tmr_load, tmr_expired;
  logic [TW-1:0] tmr_val;
  logic          can_start, last_accept;

  assign can_start   = (state_q == S_IDLE || state_q == S_DONE) && start_i;
  assign last_accept = (state_q == S_WR) && wr_ready_i && (idx_q == LAST_IDX);
  assign tmr_load    = can_start || last_accept;
  assign tmr_val     = (state_q == S_WR) ? TW'(LOCK_CYC - 1) : TW'(RST_CYC - 1);

  seq_timer #(.TW(TW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expired_o  (tmr_expired)
  );

  seq_script_rom #(.AW(AW), .DW(DW), .IW(IW)) u_rom (
    .idx_i  (idx_q),
    .addr_o (wr_addr_o),
    .data_o (wr_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      pdn_q   <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE, S_DONE: if (start_i) begin
          state_q <= S_RST;
          idx_q   <= '0;
          pdn_q   <= 1'b0;
        end
        S_RST: if (tmr_expired) begin
          state_q <= S_WR;
          pdn_q   <= 1'b1;
        end
        S_WR: if (wr_ready_i) begin
          if (idx_q == LAST_IDX) state_q <= S_LOCK;
          else                   idx_q   <= idx_q + 1'b1;
        end
        S_LOCK: if (tmr_expired) state_q <= S_DONE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign pdn_o      = pdn_q;
  assign wr_valid_o = (state_q == S_WR);
  assign busy_o     = (state_q == S_RST) || (state_q == S_WR) || (state_q == S_LOCK);
  assign done_o     = (state_q == S_DONE);

  p_no_wr_in_reset_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> pdn_o);

  p_hold_stalled_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)));

  p_busy_done_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

  p_start_pulls_pdn_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !pdn_o);

  p_done_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (pdn_o && !wr_valid_o));

  p_pdn_no_fall_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && pdn_o) |=> pdn_o);

endmodule

// File: tb/sim_codec_clk_seq.sv
module sim_codec_clk_seq;

  localparam int CLK_PERIOD = 10;
  localparam int unsigned HZ0 = 20_000_000;
  localparam int unsigned HZ1 = 25_000_000;
  localparam int unsigned LOCK_US = 2000;
  localparam int unsigned RST_NS = 150;
  // expected counts derived from the requirements
  localparam longint RST_EXP0 = (longint'(RST_NS) * HZ0 + 999_999_999) / 1_000_000_000;
  localparam longint RST_EXP1 = (longint'(RST_NS) * HZ1 + 999_999_999) / 1_000_000_000;
  localparam longint LOCK_EXP = (longint'(LOCK_US) * HZ0 + 999_999) / 1_000_000;

  logic clk = 0, rst_ni = 0, start = 0, ready = 0, start1 = 0;
  logic pdn, valid, busy, done;
  logic [7:0] addr, data;
  logic pdn1, valid1, busy1, done1;
  logic [7:0] addr1, data1;

  always #(CLK_PERIOD/2) clk = ~clk;

  codec_clk_seq #(.CLK_HZ(HZ0), .RST_LOW_NS(RST_NS), .LOCK_US(LOCK_US)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .pdn_o(pdn),
    .wr_addr_o(addr), .wr_data_o(data), .wr_valid_o(valid), .wr_ready_i(ready),
    .busy_o(busy), .done_o(done));

  codec_clk_seq #(.CLK_HZ(HZ1), .RST_LOW_NS(RST_NS), .LOCK_US(LOCK_US)) u1 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start1), .pdn_o(pdn1),
    .wr_addr_o(addr1), .wr_data_o(data1), .wr_valid_o(valid1), .wr_ready_i(1'b1),
    .busy_o(busy1), .done_o(done1));

  int checks = 0, failures = 0;
  logic [15:0] exp_q[$];
  int ready_mode = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic push_script();
    exp_q.push_back(16'h0222);
    exp_q.push_back(16'h0302);
    exp_q.push_back(16'h01F4);
    exp_q.push_back(16'h0001);
    exp_q.push_back(16'h0227);
  endtask

  // ready driver
  initial begin
    int rcnt = 0;
    forever begin
      @(posedge clk); #1;
      ready = (ready_mode == 0) ? 1'b1 : (rcnt % 3 == 2);
      rcnt++;
    end
  end

  // scoreboard monitor
  logic       hold_pend = 0;
  logic [7:0] hold_a, hold_d;
  always @(negedge clk) begin
    if (rst_ni) begin
      if (hold_pend)
        check(valid && addr == hold_a && data == hold_d, "R4", "stalled write changed",
              {valid, addr, data}, {1'b1, hold_a, hold_d});
      hold_pend = valid && !ready;
      hold_a = addr; hold_d = data;
      if (valid) check(pdn, "R3", "write while pdn low", pdn, 1);
      if (valid && ready) begin
        if (exp_q.size() == 0) check(0, "R3", "unexpected write", {addr, data}, 0);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          check({addr, data} == e, "R3", "write order", {addr, data}, e);
        end
      end
    end
  end

  task automatic pulse_start();
    @(posedge clk); #1 start = 1;
    @(posedge clk); #1 start = 0;
  endtask

  task automatic run_seq(input bit poke_busy);
    int lowcnt, lockcnt;
    push_script();
    pulse_start();
    lowcnt = 0;
    @(negedge clk);
    check(busy && !done && !pdn, "R6", "busy after start", {busy, done, pdn}, 3'b100);
    while (!pdn && lowcnt < 1000) begin
      lowcnt++;
      @(negedge clk);
    end
    check(lowcnt == RST_EXP0, "R2", "pdn low cycles", lowcnt, RST_EXP0);
    wait (exp_q.size() == 0);
    lockcnt = 0;
    while (!done && lockcnt < 100_000) begin
      @(negedge clk);
      lockcnt++;
      if (!done && (!busy || valid || !pdn)) begin
        check(0, "R5", "state during lock wait", {busy, valid, pdn}, 3'b101);
      end
      if (poke_busy && lockcnt == 100) start = 1;
      if (poke_busy && lockcnt == 102) start = 0;
    end
    check(lockcnt == LOCK_EXP + 1, poke_busy ? "R7" : "R5", "lock wait cycles",
          lockcnt, LOCK_EXP + 1);
    repeat (5) @(negedge clk);
    check(done && !busy && !valid && pdn, "R6", "done held",
          {done, busy, valid, pdn}, 4'b1001);
  endtask

  initial begin
    int lowcnt1;
    repeat (3) @(negedge clk);
    check(!pdn && !busy && !done && !valid, "R1", "in reset", {pdn, busy, done, valid}, 0);
    @(posedge clk); #1 rst_ni = 1;
    repeat (4) @(negedge clk);
    check(!pdn && !busy && !done && !valid, "R1", "idle after reset",
          {pdn, busy, done, valid}, 0);

    // rounding: 3.75 cycles -> 4
    @(posedge clk); #1 start1 = 1;
    @(posedge clk); #1 start1 = 0;
    lowcnt1 = 0;
    @(negedge clk);
    while (!pdn1 && lowcnt1 < 1000) begin
      lowcnt1++;
      @(negedge clk);
    end
    check(lowcnt1 == RST_EXP1, "R2", "rounded pdn low cycles", lowcnt1, RST_EXP1);

    ready_mode = 0;
    run_seq(0);
    ready_mode = 1;
    run_seq(1);  // restart from done (R8) with stalls and a start while busy
    check(pdn && done, "R8", "rerun completed", {pdn, done}, 2'b11);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190_000);
    failures++;
    checks++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule